// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block moves one data register to or from memory as a run of single-byte accesses whose addresses step by two. A byte-wide peripheral that sits on only one lane of a wider data bus can then be reached with one command. A start pulse latches the direction, the operand size (16 or 32 bit), a base address, a signed 16-bit displacement and the register value. The block then issues one byte request per step on a valid/ready memory port.

The memory port follows valid/ready rules. `mem_req_valid` stays high with the address, write flag and write byte held steady until `mem_req_ready` is sampled high. The whole address, control and data set is accepted on that edge. For a read, the returned byte is taken from `mem_rd_data` on that same accepting edge. A stalled slave can hold the sequencer for any number of cycles. No request fields change while it waits.

When the final byte has been accepted, `done` pulses for one cycle. For a transfer from memory to the register, `reg_out` carries the assembled value in that cycle and only then. A `start` that arrives while the block is busy is ignored.

Top module: `alt_byte_xfer`

## Requirements
- R1: The first byte address is `base_addr` plus `disp` sign-extended to the address width. Address arithmetic wraps modulo 2^AW.
- R2: Each accepted request moves exactly one byte. The request address rises by 2 after each acceptance.
- R3: When `is_long`=0 the transfer makes exactly 2 byte accesses. When `is_long`=1 it makes exactly 4.
- R4: The most significant byte of the operand is moved first, at the lowest address. The operand is bits 15:0 for word size and bits 31:0 for long size. Less significant bytes follow in order.
- R5: When `to_mem`=1 every request is a write (`mem_we`=1) carrying the operand byte given by R4. When `to_mem`=0 every request is a read (`mem_we`=0).
- R6: For a transfer from memory, the gathered bytes appear on `reg_out` only in the `done` cycle. For long size all 32 bits are replaced. For word size only bits 15:0 are replaced and bits 31:16 keep the value of `reg_in` latched at start.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte is accepted.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the address, write flag and write byte stay stable.
- R9: A `start` while `busy`=1 has no effect on the running transfer.
- R10: After reset, `busy`, `mem_req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command pulse, taken only when idle |
| to_mem | input | 1 | 1: register to memory; 0: memory to register |
| is_long | input | 1 | 1: 32-bit operand; 0: 16-bit operand |
| base_addr | input | AW | Base address |
| disp | input | 16 | Signed displacement |
| reg_in | input | 32 | Register value at start |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Byte request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Byte address |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wr_data | output | 8 | Write byte |
| mem_rd_data | input | 8 | Read byte, valid when the request is accepted |
| done | output | 1 | One-cycle completion pulse |
| reg_out | output | 32 | Assembled register value, valid with done |

## Verification
The bench uses the default address width of 24 bits. At that width a base near 0xFFFFFF together with a positive displacement checks the R1 wraparound, and a negative displacement checks that the offset is sign-extended before it is added. The ready input is driven both always-high and with stall cycles inserted, so request stability under back-pressure and per-edge byte capture are both reached. Each run is checked for both operand sizes in both directions.

// File: rtl/alt_byte_xfer_pkg.sv
package alt_byte_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/abx_addr_gen.sv
module abx_addr_gen #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_addr,
  input  logic [15:0]   disp,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] disp_ext;
  assign disp_ext = AW'($signed(disp));

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base_addr + disp_ext;
    else if (step) addr <= addr + AW'(2);
  end

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + AW'(2)));
endmodule

// File: rtl/abx_byte_shifter.sv
module abx_byte_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        is_long,
  input  logic [31:0] reg_in,
  input  logic        shift,
  input  logic [7:0]  rd_byte,
  output logic [7:0]  wr_byte,
  output logic [31:0] gathered,
  output logic [15:0] upper_keep
);
  logic [31:0] shreg;
  logic [31:0] gath;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      gath <= '0;
      upper_keep <= '0;
    end else if (load) begin
      shreg <= is_long ? reg_in : {reg_in[15:0], 16'h0};
      gath <= '0;
      upper_keep <= reg_in[31:16];
    end else if (shift) begin
      shreg <= {shreg[23:0], 8'h00};
      gath <= {gath[23:0], rd_byte};
    end
  end

  assign wr_byte  = shreg[31:24];
  assign gathered = gath;
endmodule

// File: rtl/alt_byte_xfer.sv
module alt_byte_xfer
  import alt_byte_xfer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          to_mem,
  input  logic          is_long,
  input  logic [AW-1:0] base_addr,
  input  logic [15:0]   disp,
  input  logic [31:0]   reg_in,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wr_data,
  input  logic [7:0]    mem_rd_data,
  output logic          done,
  output logic [31:0]   reg_out
);
  localparam int CW = 3;

  xfer_state_t   state;
  logic [CW-1:0] remain;
  logic          dir_wr;
  logic          long_q;
  logic          accept;
  logic          load;
  logic [31:0]   gathered;
  logic [15:0]   upper_keep;

  assign load   = (state == ST_IDLE) && start;
  assign accept = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
      dir_wr <= 1'b0;
      long_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_REQ;
          remain <= is_long ? CW'(4) : CW'(2);
          dir_wr <= to_mem;
          long_q <= is_long;
        end
        ST_REQ: if (accept) begin
          remain <= remain - CW'(1);
          if (remain == CW'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  abx_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(accept),
    .base_addr(base_addr), .disp(disp), .addr(mem_addr)
  );

  abx_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .is_long(is_long),
    .reg_in(reg_in), .shift(accept), .rd_byte(mem_rd_data),
    .wr_byte(mem_wr_data), .gathered(gathered), .upper_keep(upper_keep)
  );

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_we        = dir_wr;
  assign done          = (state == ST_DONE);
  assign reg_out       = (done && !dir_wr) ?
                         (long_q ? gathered : {upper_keep, gathered[15:0]}) : 32'h0;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wr_data)));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (remain != '0 && remain <= CW'(4)));
  p_done_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept));
endmodule

// File: tb/test_alt_byte_xfer.sv
module test_alt_byte_xfer;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0, start = 0, to_mem = 0, is_long = 0, mem_req_ready = 0;
  logic [AW-1:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic [31:0] reg_in = '0;
  logic [7:0] mem_rd_data = '0;
  logic busy, mem_req_valid, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wr_data;
  logic [31:0] reg_out;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  alt_byte_xfer #(.AW(AW)) i_alt_byte_xfer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // Runs one transfer; stall inserts that many not-ready cycles before each accept.
  task automatic run(input logic dir, input logic lng, input logic [AW-1:0] b,
                     input logic [15:0] d, input logic [31:0] r, input int stall);
    int nb;
    logic [AW-1:0] ea;
    logic [31:0] op, exp_reg;
    nb = lng ? 4 : 2;
    ea = b + AW'($signed(d));
    op = lng ? r : {r[15:0], 16'h0};
    exp_reg = lng ? 32'h0 : {r[31:16], 16'h0};
    @(negedge clk);
    to_mem = dir; is_long = lng; base_addr = b; disp = d; reg_in = r; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < nb; i++) begin
      for (int s = 0; s < stall; s++) begin
        mem_req_ready = 0;
        chk("R8 valid held", {31'h0, mem_req_valid}, 32'h1);
        chk("R8 addr held", 32'(mem_addr), 32'(ea + AW'(2*i)));
        if (i == 0 && s == 0) begin start = 1; reg_in = 32'hDEAD_BEEF; end
        @(negedge clk);
        start = 0;
      end
      chk("R2 R1 addr", 32'(mem_addr), 32'(ea + AW'(2*i)));
      chk("R5 we", {31'h0, mem_we}, {31'h0, dir});
      if (dir) chk("R4 wr byte", {24'h0, mem_wr_data}, {24'h0, op[31-8*i -: 8]});
      chk("R3 valid", {31'h0, mem_req_valid}, 32'h1);
      chk("R6 no early reg_out/done", {31'h0, done}, 32'h0);
      mem_rd_data = mem_byte(mem_addr);
      if (lng) exp_reg[31-8*i -: 8] = mem_rd_data;
      else     exp_reg[15-8*i -: 8] = mem_rd_data;
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
    end
    chk("R3 R7 done after last", {31'h0, done}, 32'h1);
    chk("R3 no extra req", {31'h0, mem_req_valid}, 32'h0);
    if (!dir) chk("R6 reg_out", reg_out, exp_reg);
    @(negedge clk);
    chk("R7 done one cycle", {31'h0, done}, 32'h0);
    chk("R7 idle", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R10 done", {31'h0, done}, 32'h0);
    rst_n = 1;
    run(1, 1, 24'h001000, 16'h0010, 32'h1122_3344, 0);
    run(1, 0, 24'h002000, 16'hFFF0, 32'hAABB_CCDD, 0);
    run(0, 1, 24'h003000, 16'h0004, 32'h0, 0);
    run(0, 0, 24'h004000, 16'h8000, 32'h9876_5432, 0);
    run(0, 0, 24'hFFFFFE, 16'h0003, 32'hCAFE_0000, 2);
    run(1, 1, 24'h000100, 16'hFFFF, 32'h0102_0304, 3);
    run(0, 1, 24'h7FFFF0, 16'h7FFF, 32'h5555_AAAA, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule